// File: doc/BRIEF.md
# Keyboard Matrix Row Multiplexer

This block gives a processor access to a keyboard matrix through one 8-bit I/O port. Software writes a select code to the port and then reads it back to fetch key data. The external matrix supplies 15 rows of 8 key bits. A bit is 1 while its key is held down. The block registers those rows on every clock edge.

A select code from 1 to 15 picks one row. One special code, 0x30, returns the OR of every row instead. Software uses that status byte to learn cheaply whether any key is down before it scans the rows one by one. All other codes read as zero, and so does the reset value of 0.

A few matrix positions have no key fitted. The block forces those bits to 0 so that a floating input never appears as a phantom key press. Reads have no side effects. The read data is a combinational function of the select register and the registered rows.

Top module: `kbd_matrix_port`

## Requirements
- R1: The port responds only when the low 8 bits of the I/O address equal 0xF4. Address bits above bit 7 are ignored, and accesses at any other low byte neither load the select register nor return data.
- R2: A write strobe to the port stores the whole 8-bit data byte in the select register at the next rising clock edge.
- R3: While the select register holds 0x30, a port read returns the bitwise OR of all 15 registered rows, with unused positions already cleared.
- R4: While the select register holds a value n from 0x01 to 0x0F, a port read returns registered row n−1. Row index 0 is the first 8-bit slice of the row input, at bits 7:0.
- R5: While the select register holds any other value (0x00, 0x10 to 0x2F, or 0x31 to 0xFF), a port read returns 0x00.
- R6: Synchronous active-high reset clears the select register and the registered rows to 0, so a port read returns 0x00 until software writes a select code.
- R7: Bit 6 of row index 5 and bits 4 and 6 of row index 6 are unused. They read as 0 in both the single-row read and the status read, whatever the row input drives.
- R8: The read data output is 0x00 in every cycle that has no read strobe aimed at the port.
- R9: The row inputs are captured on each rising clock edge. A read reflects the row values sampled at the most recent edge, not the values currently on the input.
- R10: A read has no side effects. Without a write to the port, the select register keeps its value, so repeated reads return the same row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address; only bits 7:0 are decoded |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data, the select code |
| key_rows | input | 120 | Matrix rows; row r occupies bits 8r+7:8r; 1 means pressed |
| io_rdata | output | 8 | Read data, 0 when the port is not being read |

## Verification
The assertions assume that the I/O strobes and the address are stable and free of X between clock edges. They also assume that a strobe aimed at the port is a complete access within a single cycle. Read and write strobes may coincide, and the checks hold in that case too.

The stimulus changes every input at the falling edge only and never leaves a strobe undriven. The row inputs change at the same time as the strobes, so each read exercises the one-cycle capture delay of the rows. The stimulus includes writes to neighbouring addresses and addresses whose upper bits differ, which confirms that only the low byte is decoded.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam int          DATA_W     = 8;
    localparam int          ROW_CNT    = 15;
    localparam int          IDX_W      = $clog2(ROW_CNT);
    localparam int          ROWS_W     = ROW_CNT * DATA_W;
    localparam logic [7:0]  PORT_CODE  = 8'hF4;
    localparam logic [7:0]  STATUS_SEL = 8'h30;

    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_ROW    = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    typedef struct packed {
        rd_mode_e          mode;
        logic [IDX_W-1:0]  idx;
    } rd_sel_t;

    // Bit set to 1 where a key is fitted in the matrix.
    function automatic logic [ROWS_W-1:0] fitted_mask();
        logic [ROWS_W-1:0] m;
        m = '1;
        m[5*DATA_W + 6] = 1'b0;
        m[6*DATA_W + 4] = 1'b0;
        m[6*DATA_W + 6] = 1'b0;
        return m;
    endfunction

    // Map a select code onto a read mode and row index.
    function automatic rd_sel_t decode_sel(input logic [DATA_W-1:0] code);
        rd_sel_t s;
        s.mode = RD_NONE;
        s.idx  = '0;
        if (code == STATUS_SEL) begin
            s.mode = RD_STATUS;
        end else if (code >= 8'd1 && code <= 8'(ROW_CNT)) begin
            s.mode = RD_ROW;
            s.idx  = IDX_W'(code - 8'd1);
        end
        return s;
    endfunction

endpackage

// File: rtl/kbd_port_decode.sv
module kbd_port_decode #(
    parameter int         ADDR_W = 16,
    parameter logic [7:0] CODE   = kbd_pkg::PORT_CODE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              rd_hit,
    output logic              wr_hit
);
    logic match;

    always_comb begin
        match  = (addr[7:0] == CODE);
        rd_hit = rd && match;
        wr_hit = wr && match;
    end
endmodule

// File: rtl/kbd_select_latch.sv
module kbd_select_latch
    import kbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] sel
);
    always_ff @(posedge clk) begin
        if (rst)       sel <= '0;
        else if (load) sel <= din;
    end
endmodule

// File: rtl/kbd_row_capture.sv
module kbd_row_capture
    import kbd_pkg::*;
#(
    parameter logic [ROWS_W-1:0] MASK = kbd_pkg::fitted_mask()
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ROWS_W-1:0]           rows_in,
    output logic [ROW_CNT-1:0][DATA_W-1:0] rows_q
);
    for (genvar r = 0; r < ROW_CNT; r++) begin : g_row
        localparam logic [DATA_W-1:0] RMASK = MASK[r*DATA_W +: DATA_W];
        always_ff @(posedge clk) begin
            if (rst) rows_q[r] <= '0;
            else     rows_q[r] <= rows_in[r*DATA_W +: DATA_W] & RMASK;
        end
    end
endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux
    import kbd_pkg::*;
(
    input  logic                           rd_hit,
    input  logic [DATA_W-1:0]              sel,
    input  logic [ROW_CNT-1:0][DATA_W-1:0] rows_q,
    output logic [DATA_W-1:0]              rdata
);
    rd_sel_t          dsel;
    logic [DATA_W-1:0] any_down;

    always_comb begin
        dsel     = decode_sel(sel);
        any_down = '0;
        for (int r = 0; r < ROW_CNT; r++) begin
            any_down = any_down | rows_q[r];
        end
        rdata = '0;
        if (rd_hit) begin
            case (dsel.mode)
                RD_STATUS: rdata = any_down;
                RD_ROW:    rdata = rows_q[dsel.idx];
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/kbd_matrix_port.sv
module kbd_matrix_port
    import kbd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    input  logic [119:0]      key_rows,
    output logic [7:0]        io_rdata
);
    logic                           rd_hit;
    logic                           wr_hit;
    logic [DATA_W-1:0]              sel_q;
    logic [ROW_CNT-1:0][DATA_W-1:0] rows_q;

    kbd_port_decode #(.ADDR_W(ADDR_W), .CODE(PORT_CODE)) u_dec (
        .addr   (io_addr),
        .rd     (io_rd),
        .wr     (io_wr),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    kbd_select_latch u_sel (
        .clk  (clk),
        .rst  (rst),
        .load (wr_hit),
        .din  (io_wdata),
        .sel  (sel_q)
    );

    kbd_row_capture #(.MASK(fitted_mask())) u_rows (
        .clk     (clk),
        .rst     (rst),
        .rows_in (key_rows),
        .rows_q  (rows_q)
    );

    kbd_read_mux u_mux (
        .rd_hit (rd_hit),
        .sel    (sel_q),
        .rows_q (rows_q),
        .rdata  (io_rdata)
    );
endmodule

// File: rtl/kbd_matrix_port_chk.sv
module kbd_matrix_port_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [7:0]        sel_q
);
    logic port_hit;
    assign port_hit = (io_addr[7:0] == 8'hF4);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && port_hit) |-> io_rdata == 8'h00);

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && port_hit) |=> sel_q == $past(io_wdata));

    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && port_hit) |=> $stable(sel_q));

    // R5
    bad_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && port_hit && sel_q != 8'h30 && (sel_q == 8'h00 || sel_q > 8'h0F))
        |-> io_rdata == 8'h00);

    // R7
    unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && port_hit && sel_q == 8'h07) |-> (io_rdata[4] == 1'b0 && io_rdata[6] == 1'b0));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> sel_q == 8'h00);
endmodule

bind kbd_matrix_port kbd_matrix_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .sel_q    (sel_q)
);

// File: tb/kbd_matrix_port_test.sv
module kbd_matrix_port_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  io_addr = '0;
    logic         io_rd = 1'b0;
    logic         io_wr = 1'b0;
    logic [7:0]   io_wdata = '0;
    logic [119:0] key_rows = '0;
    logic [7:0]   io_rdata;

    int tests  = 0;
    int failed = 0;
    int  m_sel = 0;
    logic [7:0] m_row [15];

    kbd_matrix_port uut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .key_rows(key_rows), .io_rdata(io_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] cleaned(int r);
        logic [7:0] v = m_row[r];
        if (r == 5) v[6] = 1'b0;
        if (r == 6) begin v[4] = 1'b0; v[6] = 1'b0; end
        return v;
    endfunction

    function automatic logic [7:0] expect_rd();
        logic [7:0] acc = 8'h00;
        if (!(io_rd && io_addr[7:0] == 8'hF4)) return 8'h00;
        if (m_sel == 'h30) begin
            for (int r = 0; r < 15; r++) acc |= cleaned(r);
            return acc;
        end
        if (m_sel >= 1 && m_sel <= 15) return cleaned(m_sel - 1);
        return 8'h00;
    endfunction

    // Drive one cycle at the falling edge, compare, then advance the model.
    task automatic cyc(input logic [15:0] a, input logic rd, input logic wr,
                       input logic [7:0] wd, input string tag);
        logic [7:0] exp;
        io_addr = a; io_rd = rd; io_wr = wr; io_wdata = wd;
        #1;
        exp = expect_rd();
        tests++;
        if (io_rdata !== exp) begin
            failed++;
            $display("FAIL %s: rdata=%02h expected=%02h (sel=%02h)", tag, io_rdata, exp, m_sel);
        end
        @(posedge clk);
        if (rst) begin
            m_sel = 0;
            for (int r = 0; r < 15; r++) m_row[r] = 8'h00;
        end else begin
            if (wr && a[7:0] == 8'hF4) m_sel = int'(wd);
            for (int r = 0; r < 15; r++) m_row[r] = key_rows[r*8 +: 8];
        end
        @(negedge clk);
    endtask

    task automatic set_row(input int r, input logic [7:0] v);
        key_rows[r*8 +: 8] = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failed++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        for (int r = 0; r < 15; r++) m_row[r] = 8'h00;
        @(negedge clk);
        for (int r = 0; r < 15; r++) set_row(r, 8'(8'h11 * r + 1));
        cyc(16'h00F4, 1, 0, 8'h00, "R6 in reset");
        cyc(16'h00F4, 0, 1, 8'h30, "R6 in reset write");
        rst = 1'b0;
        cyc(16'h00F4, 1, 0, 8'h00, "R6 after reset");
        cyc(16'h00F4, 1, 0, 8'h00, "R6 select zero");

        // R4: each row in turn, patterns change with the select
        for (int n = 1; n <= 15; n++) begin
            set_row(n - 1, 8'(8'hA5 ^ (n * 8'h13)));
            cyc(16'h00F4, 0, 1, 8'(n), "R2 write select");
            cyc(16'h00F4, 1, 0, 8'h00, "R4 row read");
        end

        // R10: repeated reads keep the selection
        cyc(16'h00F4, 0, 1, 8'h03, "R2 write 03");
        for (int k = 0; k < 4; k++) cyc(16'h00F4, 1, 0, 8'h00, "R10 repeat read");

        // R9: new row value visible one edge later
        set_row(2, 8'h5A);
        cyc(16'h00F4, 1, 0, 8'h00, "R9 before capture");
        set_row(2, 8'hC3);
        cyc(16'h00F4, 1, 0, 8'h00, "R9 after capture");

        // R7: unused positions cleared
        set_row(5, 8'hFF); set_row(6, 8'hFF);
        cyc(16'h00F4, 0, 1, 8'h06, "R7 select row5");
        cyc(16'h00F4, 1, 0, 8'h00, "R7 row index 5");
        cyc(16'h00F4, 0, 1, 8'h07, "R7 select row6");
        cyc(16'h00F4, 1, 0, 8'h00, "R7 row index 6");

        // R3: status OR under several patterns
        cyc(16'h00F4, 0, 1, 8'h30, "R3 select status");
        key_rows = '0;
        cyc(16'h00F4, 1, 0, 8'h00, "R3 status settle");
        cyc(16'h00F4, 1, 0, 8'h00, "R3 status none down");
        set_row(6, 8'h50);
        cyc(16'h00F4, 1, 0, 8'h00, "R3 capture");
        cyc(16'h00F4, 1, 0, 8'h00, "R3 R7 only unused bits");
        set_row(0, 8'h01); set_row(14, 8'h80); set_row(9, 8'h20);
        cyc(16'h00F4, 1, 0, 8'h00, "R3 capture");
        cyc(16'h00F4, 1, 0, 8'h00, "R3 status several rows");
        key_rows = '1;
        cyc(16'h00F4, 1, 0, 8'h00, "R3 capture");
        cyc(16'h00F4, 1, 0, 8'h00, "R3 status all down");

        // R5: other codes
        cyc(16'h00F4, 0, 1, 8'h10, "R5 write 10");
        cyc(16'h00F4, 1, 0, 8'h00, "R5 code 10");
        cyc(16'h00F4, 0, 1, 8'h31, "R5 write 31");
        cyc(16'h00F4, 1, 0, 8'h00, "R5 code 31");
        cyc(16'h00F4, 0, 1, 8'hFF, "R5 write FF");
        cyc(16'h00F4, 1, 0, 8'h00, "R5 code FF");
        cyc(16'h00F4, 0, 1, 8'h2F, "R5 write 2F");
        cyc(16'h00F4, 1, 0, 8'h00, "R5 code 2F");

        // R1: decode of the low byte only
        cyc(16'h00F4, 0, 1, 8'h01, "R1 write 01");
        cyc(16'h00F5, 0, 1, 8'h30, "R1 write other port");
        cyc(16'h00F4, 1, 0, 8'h00, "R1 select unchanged");
        cyc(16'h00F3, 1, 0, 8'h00, "R1 read other port");
        cyc(16'h12F4, 0, 1, 8'h30, "R1 upper bits ignored write");
        cyc(16'hABF4, 1, 0, 8'h00, "R1 upper bits ignored read");

        // R8: no strobe gives zero
        cyc(16'h00F4, 0, 0, 8'h00, "R8 no strobe");
        cyc(16'h00F4, 0, 1, 8'h01, "R8 write only");

        // Simultaneous read and write
        cyc(16'h00F4, 1, 1, 8'h30, "R2 read with write");
        cyc(16'h00F4, 1, 0, 8'h00, "R2 new select used");

        // Reset again mid-run
        rst = 1'b1;
        cyc(16'h00F4, 0, 0, 8'h00, "R6 reset pulse");
        rst = 1'b0;
        cyc(16'h00F4, 1, 0, 8'h00, "R6 select cleared");

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule